// File: doc/BRIEF.md
# Multicycle Instruction Cycle Sequencer

This block is the control unit of a small accumulator processor. It steps every instruction through a fixed series of register transfers: the program counter is copied into the memory address register, a memory read returns the instruction word into the memory buffer register, and that word moves into the instruction register. If the instruction names its operand indirectly, one extra read fetches the real operand address. The instruction then executes. Before the next fetch starts, the sequencer checks for an interrupt.

When an interrupt is taken, the current program counter goes into the buffer register and is written to a fixed save location. The enable is then cleared and the program counter is loaded with a fixed handler vector. A return instruction reads the save location back into the program counter and sets the enable again. All traffic goes to one single-port memory. Each access is held until that memory raises its ready signal.

Top module: `icyc_sequencer`

## Requirements
- R1: While reset is low, the program counter, accumulator and interrupt enable are zero and no write is driven. After reset is released, the first completed access is a read of address 0.
- R2: Each fetch reads at the program counter. The program counter rises by one, wrapping within the address width, in the cycle after that fetch read completes.
- R3: An instruction word carries the indirect flag in bit 15, the opcode in bits 14:12 and an address in bits 11:0. The opcodes are: 1 loads the accumulator from memory; 2 adds the memory word to the accumulator modulo 2^16; 3 stores the accumulator; 4 jumps to the effective address; 6 sets the interrupt enable; 7 returns from an interrupt. Opcodes 0 and 5 do nothing.
- R4: For opcodes 1 to 4 with bit 15 set, one extra read at the address field runs before execution. The low 12 bits of the word it returns become the effective address. For every other opcode the flag is ignored and no extra read takes place.
- R5: A pending access keeps its strobe, address and write data steady until ready is seen high. The sequencer moves on in the cycle after.
- R6: The read and write strobes are never high together.
- R7: The interrupt request is sampled only after an instruction has finished all of its memory traffic. While the enable is zero, the request is ignored.
- R8: Taking an interrupt writes the program counter of the next instruction to the save location (default 0x0FF) with the enable already cleared. The program counter is then loaded with the handler vector (default 0x100), and the next read is a fetch from that vector.
- R9: The return opcode reads the save location, loads the program counter from it and sets the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Memory address (the address register) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while ready is high |
| mem_ready | input | 1 | Access completes at the edge where this is high |
| irq | input | 1 | Level-sensitive interrupt request |
| pc_o | output | 12 | Current program counter |
| acc_o | output | 16 | Current accumulator |
| int_en_o | output | 1 | Current interrupt enable |

## Verification
Two events can fall in the same cycle: a rising interrupt request and a memory access that is still waiting for ready. The bench provokes this with a slow memory. It raises the request just after the fetch of an indirect store, while the pointer read and the store write are still pending. It then judges the order of completed accesses. The pointer read and the store write must finish before the save write. The saved value must be the address of the following instruction. The first read after the save must be the fetch at the vector, and the return must resume at the saved address with the enable set again.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

    typedef enum logic [3:0] {
        S_FI_ADDR,
        S_FI_READ,
        S_DECODE,
        S_IND_READ,
        S_IND_MAR,
        S_EXEC,
        S_RET_READ,
        S_RET_PC,
        S_ICHK,
        S_INT_WR
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_LOAD  = 3'd1,
        OP_ADD   = 3'd2,
        OP_STORE = 3'd3,
        OP_JUMP  = 3'd4,
        OP_SPARE = 3'd5,
        OP_INTEN = 3'd6,
        OP_RETI  = 3'd7
    } opcode_e;

endpackage

// File: rtl/icyc_decode.sv
module icyc_decode
    import icyc_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 12
) (
    input  logic [DW-1:0] word_i,
    output opcode_e       op_o,
    output logic          take_ind_o,
    output logic [AW-1:0] field_o
);

    localparam int IND_BIT = DW - 1;
    localparam int OP_LSB  = AW;

    logic needs_operand;

    always_comb begin
        op_o          = opcode_e'(word_i[OP_LSB+2:OP_LSB]);
        field_o       = word_i[AW-1:0];
        needs_operand = (op_o == OP_LOAD) || (op_o == OP_ADD) ||
                        (op_o == OP_STORE) || (op_o == OP_JUMP);
        take_ind_o    = word_i[IND_BIT] && needs_operand;
    end

endmodule

// File: rtl/icyc_acc_unit.sv
module icyc_acc_unit
    import icyc_pkg::*;
#(
    parameter int DW = 16
) (
    input  opcode_e       op_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] operand_i,
    output logic [DW-1:0] acc_o
);

    always_comb begin
        unique case (op_i)
            OP_LOAD: acc_o = operand_i;
            OP_ADD:  acc_o = acc_i + operand_i;
            default: acc_o = acc_i;
        endcase
    end

endmodule

// File: rtl/icyc_sequencer.sv
module icyc_sequencer
    import icyc_pkg::*;
#(
    parameter int          DW        = 16,
    parameter int          AW        = 12,
    parameter logic [11:0] SAVE_ADDR = 12'h0FF,
    parameter logic [11:0] VEC_ADDR  = 12'h100
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    input  logic          irq,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] acc_o,
    output logic          int_en_o
);

    localparam int          PAD     = DW - AW;
    localparam logic [AW-1:0] SAVE_A = AW'(SAVE_ADDR);
    localparam logic [AW-1:0] VEC_A  = AW'(VEC_ADDR);
    localparam logic [AW-1:0] PC_ONE = AW'(1);

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] pc;
        logic [AW-1:0] mar;
        logic [DW-1:0] mbr;
        logic [DW-1:0] ir;
        logic [DW-1:0] acc;
        logic          ie;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [DW-1:0] dec_word;
    opcode_e       dec_op;
    logic          dec_ind;
    logic [AW-1:0] dec_field;
    logic [DW-1:0] acc_next;

    assign dec_word = (r_q.st == S_DECODE) ? r_q.mbr : r_q.ir;

    icyc_decode #(.DW(DW), .AW(AW)) u_decode (
        .word_i     (dec_word),
        .op_o       (dec_op),
        .take_ind_o (dec_ind),
        .field_o    (dec_field)
    );

    icyc_acc_unit #(.DW(DW)) u_acc (
        .op_i      (dec_op),
        .acc_i     (r_q.acc),
        .operand_i (mem_rdata),
        .acc_o     (acc_next)
    );

    // Bus strobes come straight from the registered state
    always_comb begin
        mem_addr  = r_q.mar;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = r_q.acc;
        unique case (r_q.st)
            S_FI_READ, S_IND_READ, S_RET_READ: mem_rd = 1'b1;
            S_EXEC: begin
                mem_rd = (dec_op == OP_LOAD) || (dec_op == OP_ADD);
                mem_wr = (dec_op == OP_STORE);
            end
            S_INT_WR: begin
                mem_wr    = 1'b1;
                mem_wdata = r_q.mbr;
            end
            default: ;
        endcase
    end

    // Next-state computation
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_FI_ADDR: begin
                r_d.mar = r_q.pc;
                r_d.st  = S_FI_READ;
            end
            S_FI_READ: begin
                if (mem_ready) begin
                    r_d.mbr = mem_rdata;
                    r_d.pc  = r_q.pc + PC_ONE;
                    r_d.st  = S_DECODE;
                end
            end
            S_DECODE: begin
                r_d.ir  = r_q.mbr;
                r_d.mar = dec_field;
                r_d.st  = dec_ind ? S_IND_READ : S_EXEC;
            end
            S_IND_READ: begin
                if (mem_ready) begin
                    r_d.mbr = mem_rdata;
                    r_d.st  = S_IND_MAR;
                end
            end
            S_IND_MAR: begin
                r_d.mar = r_q.mbr[AW-1:0];
                r_d.st  = S_EXEC;
            end
            S_EXEC: begin
                unique case (dec_op)
                    OP_LOAD, OP_ADD, OP_STORE: begin
                        if (mem_ready) begin
                            r_d.acc = acc_next;
                            r_d.st  = S_ICHK;
                        end
                    end
                    OP_JUMP: begin
                        r_d.pc = r_q.mar;
                        r_d.st = S_ICHK;
                    end
                    OP_INTEN: begin
                        r_d.ie = 1'b1;
                        r_d.st = S_ICHK;
                    end
                    OP_RETI: begin
                        r_d.mar = SAVE_A;
                        r_d.st  = S_RET_READ;
                    end
                    default: r_d.st = S_ICHK;
                endcase
            end
            S_RET_READ: begin
                if (mem_ready) begin
                    r_d.mbr = mem_rdata;
                    r_d.st  = S_RET_PC;
                end
            end
            S_RET_PC: begin
                r_d.pc = r_q.mbr[AW-1:0];
                r_d.ie = 1'b1;
                r_d.st = S_ICHK;
            end
            S_ICHK: begin
                if (r_q.ie && irq) begin
                    r_d.mbr = {{PAD{1'b0}}, r_q.pc};
                    r_d.mar = SAVE_A;
                    r_d.ie  = 1'b0;
                    r_d.st  = S_INT_WR;
                end else begin
                    r_d.st = S_FI_ADDR;
                end
            end
            S_INT_WR: begin
                if (mem_ready) begin
                    r_d.pc = VEC_A;
                    r_d.st = S_FI_ADDR;
                end
            end
            default: r_d.st = S_FI_ADDR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= S_FI_ADDR;
            r_q.pc  <= '0;
            r_q.mar <= '0;
            r_q.mbr <= '0;
            r_q.ir  <= '0;
            r_q.acc <= '0;
            r_q.ie  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc_o     = r_q.pc;
    assign acc_o    = r_q.acc;
    assign int_en_o = r_q.ie;

    // Protocol and sequencing checks
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R6

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr))); // R5

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata))); // R5

    AST_FETCH_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_FI_READ && mem_ready) |=> (pc_o == AW'($past(pc_o) + PC_ONE))); // R2

    AST_SAVE_IE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && (r_q.st == S_INT_WR) |-> !int_en_o && mem_addr == SAVE_A); // R8

    AST_VECTOR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_INT_WR && mem_ready) |=> (pc_o == VEC_A && !mem_rd && !mem_wr)); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_ICHK && !int_en_o) |=> (r_q.st == S_FI_ADDR)); // R7

    AST_RETURN_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_RET_PC) |=> int_en_o); // R9

endmodule

// File: tb/test_icyc_sequencer.sv
`timescale 1ns/1ps
module test_icyc_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        mem_ready;
    logic        irq = 1'b0;
    logic [11:0] pc_o;
    logic [15:0] acc_o;
    logic        int_en_o;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    icyc_sequencer i_icyc_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .irq       (irq),
        .pc_o      (pc_o),
        .acc_o     (acc_o),
        .int_en_o  (int_en_o)
    );

    // Memory model with programmable wait states
    logic [15:0] mem [0:4095];
    int          lat = 0;
    int          wait_ctr;
    logic        clr = 1'b0;
    logic        ld_en = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [15:0] ld_data = '0;

    assign mem_rdata = mem[mem_addr];
    assign mem_ready = (mem_rd || mem_wr) && (wait_ctr == lat);

    always @(posedge clk) begin
        if (!rst_n) wait_ctr <= 0;
        else if ((mem_rd || mem_wr) && !mem_ready) wait_ctr <= wait_ctr + 1;
        else wait_ctr <= 0;
    end

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 4096; i++) mem[i] <= 16'h0000;
        end else if (ld_en) begin
            mem[ld_addr] <= ld_data;
        end else if (rst_n && mem_wr && mem_ready) begin
            mem[mem_addr] <= mem_wdata;
        end
    end

    // Logs of completed accesses
    logic [11:0] rlog [0:31];
    logic [11:0] wlog [0:7];
    int          rnum, wnum;

    always @(posedge clk) begin
        if (!rst_n) begin
            rnum <= 0;
            wnum <= 0;
        end else begin
            if (mem_rd && mem_ready) begin
                if (rnum < 32) rlog[rnum] <= mem_addr;
                rnum <= rnum + 1;
            end
            if (mem_wr && mem_ready) begin
                if (wnum < 8) wlog[wnum] <= mem_addr;
                wnum <= wnum + 1;
            end
        end
    end

    function automatic logic [15:0] mk(input logic ind, input logic [2:0] op, input logic [11:0] a);
        return {ind, op, a};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic begin_test(input int latency);
        @(negedge clk);
        rst_n = 1'b0;
        irq   = 1'b0;
        lat   = latency;
        clr   = 1'b1;
        @(negedge clk);
        clr   = 1'b0;
    endtask

    task automatic poke(input logic [11:0] a, input logic [15:0] d);
        ld_addr = a;
        ld_data = d;
        ld_en   = 1'b1;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_reads(input int n);
        int guard = 0;
        while (rnum < n && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic wait_writes(input int n);
        int guard = 0;
        while (wnum < n && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic test_reset();
        begin_test(0);
        poke(12'h000, mk(0, 3'd4, 12'h000));
        run(2);
        chk("R1", "pc in reset", 32'(pc_o), 32'h0);
        chk("R1", "acc in reset", 32'(acc_o), 32'h0);
        chk("R1", "enable in reset", 32'(int_en_o), 32'h0);
        chk("R1", "no write in reset", 32'(mem_wr), 32'h0);
        release_reset();
        run(10);
        chk("R1", "first read address", 32'(rlog[0]), 32'h000);
    endtask

    task automatic test_direct(input int latency, input logic [15:0] a, input logic [15:0] b);
        logic [15:0] sum = a + b;
        begin_test(latency);
        poke(12'h000, mk(0, 3'd1, 12'h200));
        poke(12'h001, mk(0, 3'd2, 12'h201));
        poke(12'h002, mk(0, 3'd3, 12'h202));
        poke(12'h003, mk(0, 3'd4, 12'h003));
        poke(12'h200, a);
        poke(12'h201, b);
        release_reset();
        run(200);
        chk("R3", "accumulator after load+add", 32'(acc_o), 32'(sum));
        chk("R3", "stored sum", 32'(mem[12'h202]), 32'(sum));
        chk("R2", "fetch order read1", 32'(rlog[1]), 32'h200);
        chk("R2", "fetch order read2", 32'(rlog[2]), 32'h001);
        chk("R2", "fetch order read4", 32'(rlog[4]), 32'h002);
        chk("R2", "fetch order read5", 32'(rlog[5]), 32'h003);
        chk("R5", "one write only", 32'(wnum), 32'd1);
    endtask

    task automatic test_indirect();
        begin_test(1);
        poke(12'h000, mk(1, 3'd1, 12'h210));
        poke(12'h001, mk(1, 3'd3, 12'h211));
        poke(12'h002, mk(1, 3'd4, 12'h212));
        poke(12'h005, mk(0, 3'd4, 12'h005));
        poke(12'h210, 16'hF220);
        poke(12'h211, 16'h0230);
        poke(12'h212, 16'h0005);
        poke(12'h220, 16'h0033);
        poke(12'h230, 16'hBEEF);
        release_reset();
        run(250);
        chk("R4", "pointer read", 32'(rlog[1]), 32'h210);
        chk("R4", "operand read low 12 bits", 32'(rlog[2]), 32'h220);
        chk("R4", "indirect load value", 32'(acc_o), 32'h33);
        chk("R4", "indirect store target", 32'(mem[12'h230]), 32'h33);
        chk("R4", "indirect jump pointer read", 32'(rlog[6]), 32'h212);
        chk("R4", "indirect jump lands", 32'(rlog[7]), 32'h005);
    endtask

    task automatic test_flag_ignored();
        begin_test(0);
        poke(12'h000, mk(1, 3'd6, 12'h123));
        poke(12'h001, mk(1, 3'd0, 12'h124));
        poke(12'h002, mk(0, 3'd4, 12'h002));
        release_reset();
        run(100);
        chk("R4", "no extra read for enable op", 32'(rlog[1]), 32'h001);
        chk("R4", "no extra read for no-op", 32'(rlog[2]), 32'h002);
        chk("R3", "enable opcode sets enable", 32'(int_en_o), 32'h1);
    endtask

    task automatic test_masked();
        begin_test(0);
        poke(12'h000, mk(0, 3'd1, 12'h200));
        poke(12'h001, mk(0, 3'd3, 12'h202));
        poke(12'h002, mk(0, 3'd4, 12'h002));
        poke(12'h200, 16'h0042);
        poke(12'h0FF, 16'hA5A5);
        irq = 1'b1;
        release_reset();
        run(150);
        chk("R7", "masked request: writes", 32'(wnum), 32'd1);
        chk("R7", "masked request: save untouched", 32'(mem[12'h0FF]), 32'hA5A5);
        chk("R7", "masked request: stays in loop", 32'(rlog[4]), 32'h002);
        chk("R7", "masked request: enable low", 32'(int_en_o), 32'h0);
        irq = 1'b0;
    endtask

    task automatic test_interrupt();
        begin_test(2);
        poke(12'h000, mk(0, 3'd6, 12'h000));
        poke(12'h001, mk(1, 3'd3, 12'h211));
        poke(12'h002, mk(0, 3'd4, 12'h002));
        poke(12'h100, mk(0, 3'd1, 12'h200));
        poke(12'h101, mk(0, 3'd3, 12'h203));
        poke(12'h102, mk(0, 3'd7, 12'h000));
        poke(12'h200, 16'h0055);
        poke(12'h211, 16'h0230);
        poke(12'h230, 16'hBEEF);
        release_reset();
        wait_reads(2);
        irq = 1'b1;
        wait_writes(2);
        chk("R8", "enable clear after save", 32'(int_en_o), 32'h0);
        irq = 1'b0;
        run(300);
        chk("R7", "store finishes before save", 32'(wlog[0]), 32'h230);
        chk("R7", "stored accumulator", 32'(mem[12'h230]), 32'h0);
        chk("R7", "pointer read before save", 32'(rlog[2]), 32'h211);
        chk("R8", "save location", 32'(wlog[1]), 32'h0FF);
        chk("R8", "saved next pc", 32'(mem[12'h0FF]), 32'h002);
        chk("R8", "first read after save is vector", 32'(rlog[3]), 32'h100);
        chk("R8", "handler stored value", 32'(mem[12'h203]), 32'h55);
        chk("R9", "return reads save location", 32'(rlog[7]), 32'h0FF);
        chk("R9", "resume at saved address", 32'(rlog[8]), 32'h002);
        chk("R9", "enable set after return", 32'(int_en_o), 32'h1);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        test_reset();
        test_direct(0, 16'h0005, 16'h0007);
        test_direct(3, 16'hFFFF, 16'h0002);
        test_indirect();
        test_flag_ignored();
        test_masked();
        test_interrupt();
        finish_run();
    end

endmodule